// File: doc/BRIEF.md
# Ethernet MAC Frame Statistics Counters

This block keeps the traffic statistics of a single Ethernet MAC. The transmit and receive paths each hand it a one-cycle frame summary when a frame completes. The summary gives the frame length with the 4-octet FCS included, and flags for VLAN tag, good or bad status, group (multicast) destination, all-ones (broadcast) destination and, on transmit only, PAUSE control frame. The receive path also gives a raw strobe, one pulse per octet seen on the line, including octets of frames that are later dropped. The block does not parse frames and uses the flags as given.

From these inputs the block maintains length-bin counters, octet counters and address-class counters for each direction. A word-addressed register port reads and writes every counter. The same port reaches a carry register that records counter wraparound, a carry mask, and a minimum-length setting. The interrupt output is asserted while any carry bit that is not masked off is set. The register read path is combinational. The register address map is: counters at addresses 0 to 14 in the order of requirement R12, the carry register at 16, the carry mask at 17 and the minimum-length setting at 18.

Top module: `mac_stats_counters`

## Requirements
- R1: After reset, every counter, the carry register, the mask and the minimum-length setting read 0, and `irq` is low.
- R2: When no programmable minimum is enabled, the minimum-length bin counts a frame only when its length equals 64 (untagged) or 68 (VLAN-tagged). Bad frames count as well as good ones.
- R3: Address 18 holds the programmable minimum: bits 15:0 give the length and bit 16 enables it. While it is enabled, that length replaces both 64 and 68 for every length decision.
- R4: The middle bin counts lengths from the minimum plus 1 up to 127. The upper bin counts lengths from 128 up to 255. Frames shorter than the minimum or longer than 255 update no bin, and bad frames count in every bin.
- R5: The transmit octet counter (address 6) adds the length of good transmit frames only. The receive good-octet counter (address 11) adds the length of good receive frames only.
- R6: The raw receive octet counter (address 12) adds 1 for each cycle in which `rx_octet_stb` is high, whether or not a frame summary arrives.
- R7: The multicast counters (transmit address 8, receive address 13) count good frames that have the group flag set and the broadcast flag clear. The broadcast counters (addresses 9 and 14) count good frames that have the broadcast flag set. Bad frames update neither counter.
- R8: The transmit PAUSE counter (address 7) is 16 bits wide and counts good transmit PAUSE frames. The receive good-frame counter (address 10) counts good receive frames.
- R9: A register write to a counter address loads the written data, so writing 0 clears the counter. The write wins over an increment in the same cycle.
- R10: When a counter wraps past its maximum, bit n of the carry register (address 16) is set, where n is that counter's address. Writing 1 to a carry bit clears it, but a wrap in the same cycle keeps the bit set.
- R11: `irq` is high exactly when some bit is set in both the carry register and the mask register (address 17, 1 = enabled).
- R12: Counter addresses are: 0/1/2 transmit min/mid/upper bin, 3/4/5 receive min/mid/upper bin, 6 transmit octets, 7 transmit PAUSE, 8 transmit multicast, 9 transmit broadcast, 10 receive good frames, 11 receive good octets, 12 receive raw octets, 13 receive multicast, 14 receive broadcast. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_evt_valid | input | 1 | Transmit frame summary valid, one cycle per frame |
| tx_evt_len | input | 16 | Transmit frame length in octets, FCS included |
| tx_evt_vlan | input | 1 | Transmit frame carries a VLAN tag |
| tx_evt_ok | input | 1 | Transmit frame was sent successfully |
| tx_evt_mcast | input | 1 | Transmit destination group bit set |
| tx_evt_bcast | input | 1 | Transmit destination is all ones |
| tx_evt_pause | input | 1 | Transmit frame is a PAUSE control frame |
| rx_evt_valid | input | 1 | Receive frame summary valid, one cycle per frame |
| rx_evt_len | input | 16 | Receive frame length in octets, FCS included |
| rx_evt_vlan | input | 1 | Receive frame carries a VLAN tag |
| rx_evt_ok | input | 1 | Receive frame was received without error |
| rx_evt_mcast | input | 1 | Receive destination group bit set |
| rx_evt_bcast | input | 1 | Receive destination is all ones |
| rx_octet_stb | input | 1 | One pulse per raw received octet |
| reg_addr | input | 5 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Unmasked carry pending |

## Verification
A wrong bin decision or a wrong flag qualifier shows up as a counter read that is off by one immediately after the frame's clock edge. The bench therefore reads the counters before and after every frame and compares the difference. A fault in the adder or the wrap detection is hidden until a counter reaches its top, so the counters are preloaded to within a few counts of wrapping. That exposes the wrong value or the missing carry bit within one frame. A wrong carry clear or mask priority shows on `irq` in the cycle after the register write.

// File: rtl/mac_stats_pkg.sv
// Package: shared sizes, counter indices and register addresses for the
// MAC statistics block. Assumes counter n sits at register word n.
package mac_stats_pkg;
    localparam int NUM_CNT   = 15;
    localparam int CNT_W     = 32;
    localparam int PAUSE_W   = 16;
    localparam int LEN_W     = 16;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 32;

    localparam int IDX_TX_MIN    = 0;
    localparam int IDX_TX_MID    = 1;
    localparam int IDX_TX_HI     = 2;
    localparam int IDX_RX_MIN    = 3;
    localparam int IDX_RX_MID    = 4;
    localparam int IDX_RX_HI     = 5;
    localparam int IDX_TX_OCT    = 6;
    localparam int IDX_TX_PAUSE  = 7;
    localparam int IDX_TX_MC     = 8;
    localparam int IDX_TX_BC     = 9;
    localparam int IDX_RX_FRM    = 10;
    localparam int IDX_RX_OCT    = 11;
    localparam int IDX_RX_RAW    = 12;
    localparam int IDX_RX_MC     = 13;
    localparam int IDX_RX_BC     = 14;

    localparam int ADDR_CARRY  = 16;
    localparam int ADDR_MASK   = 17;
    localparam int ADDR_MINLEN = 18;

    // Width of the counter at a given index (the PAUSE counter is narrow).
    function automatic int cnt_width(int idx);
        return (idx == IDX_TX_PAUSE) ? PAUSE_W : CNT_W;
    endfunction
endpackage

// File: rtl/mac_stats_classify.sv
// Module: per-direction frame classifier. Turns one frame summary into
// length-bin hits and qualified address-class strobes. Purely combinational;
// assumes the caller qualifies nothing further and trusts the flags.
module mac_stats_classify #(
    parameter int LEN_W    = 16,
    parameter int MIN_UNTAG = 64,
    parameter int MIN_TAG   = 68,
    parameter int MID_TOP   = 127,
    parameter int HI_BOT    = 128,
    parameter int HI_TOP    = 255
) (
    input  logic             valid,
    input  logic [LEN_W-1:0] len,
    input  logic             vlan,
    input  logic             ok,
    input  logic             mcast,
    input  logic             bcast,
    input  logic             min_en,
    input  logic [LEN_W-1:0] min_val,
    output logic             bin_min,
    output logic             bin_mid,
    output logic             bin_hi,
    output logic             good,
    output logic             good_mc,
    output logic             good_bc
);
    localparam logic [LEN_W-1:0] L_UNTAG = LEN_W'(MIN_UNTAG);
    localparam logic [LEN_W-1:0] L_TAG   = LEN_W'(MIN_TAG);
    localparam logic [LEN_W-1:0] L_MIDT  = LEN_W'(MID_TOP);
    localparam logic [LEN_W-1:0] L_HIB   = LEN_W'(HI_BOT);
    localparam logic [LEN_W-1:0] L_HIT   = LEN_W'(HI_TOP);

    logic [LEN_W-1:0] min_len;

    // Pick the active minimum: programmed value, else tag-dependent default.
    always_comb begin
        if (min_en)
            min_len = min_val;
        else if (vlan)
            min_len = L_TAG;
        else
            min_len = L_UNTAG;
    end

    // Length bins count every frame, good or bad.
    always_comb begin
        bin_min = valid && (len == min_len);
        bin_mid = valid && (len > min_len) && (len <= L_MIDT);
        bin_hi  = valid && (len >= L_HIB) && (len <= L_HIT) && (len > min_len);
    end

    // Address classes count good frames only; broadcast excludes multicast.
    always_comb begin
        good    = valid && ok;
        good_mc = valid && ok && mcast && !bcast;
        good_bc = valid && ok && bcast;
    end
endmodule

// File: rtl/mac_stats_counter.sv
// Module: one statistics counter. Adds an amount when enabled, loads the
// write data when written (write wins), and flags a wrap for the carry
// register. Assumes AMT_W <= W.
module mac_stats_counter #(
    parameter int W     = 32,
    parameter int AMT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [AMT_W-1:0] amt,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     value,
    output logic             wrap
);
    logic [W-1:0] cnt_q;
    logic [W:0]   sum;

    // Extended sum so the carry-out marks a wrap.
    always_comb begin
        sum  = {1'b0, cnt_q} + (W+1)'(amt);
        wrap = inc && !wr && sum[W];
    end

    // Counter register: write first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr)
            cnt_q <= wdata;
        else if (inc)
            cnt_q <= sum[W-1:0];
    end

    assign value = cnt_q;

    // R5/R6/R8: an increment without a write advances by exactly the amount.
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr) |=> (cnt_q == $past(cnt_q) + W'($past(amt))));

    // R9: a write always lands, whatever the increment does.
    assert_write_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt_q == $past(wdata)));

    // R1: idle counter holds.
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr) |=> $stable(cnt_q));
endmodule

// File: rtl/mac_stats_carry.sv
// Module: carry (wrap) register with write-one-to-clear, its mask and the
// combined interrupt. Assumes wrap pulses last one cycle per wrap.
module mac_stats_carry #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wrap,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_data,
    output logic [N-1:0] carry,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] carry_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] clr_vec;

    // Bits to clear this cycle.
    assign clr_vec = clr_en ? clr_bits : '0;

    // Carry register: clear requested bits, then set wrapped ones (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= '0;
        else
            carry_q <= (carry_q & ~clr_vec) | wrap;
    end

    // Mask register: plain load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= mask_data;
    end

    assign carry = carry_q;
    assign mask  = mask_q;
    assign irq   = |(carry_q & mask_q);

    // R10: every wrap is recorded on the next edge, even under a clear.
    assert_wrap_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> ((carry_q & $past(wrap)) == $past(wrap)));

    // R10: a carry bit never appears without a wrap behind it.
    assert_no_spurious_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((carry_q & ~$past(carry_q) & ~$past(wrap)) == '0));

    // R11: with nothing pending there is no interrupt.
    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_q == '0) |-> !irq);
endmodule

// File: rtl/mac_stats_counters.sv
// Module: top of the MAC statistics block. Classifies transmit and receive
// frame summaries, drives fifteen counters, the carry/mask logic and a
// word-addressed register port. Assumes one summary per direction per cycle
// at most, and trusts all frame flags.
module mac_stats_counters
    import mac_stats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_evt_valid,
    input  logic [LEN_W-1:0]  tx_evt_len,
    input  logic              tx_evt_vlan,
    input  logic              tx_evt_ok,
    input  logic              tx_evt_mcast,
    input  logic              tx_evt_bcast,
    input  logic              tx_evt_pause,
    input  logic              rx_evt_valid,
    input  logic [LEN_W-1:0]  rx_evt_len,
    input  logic              rx_evt_vlan,
    input  logic              rx_evt_ok,
    input  logic              rx_evt_mcast,
    input  logic              rx_evt_bcast,
    input  logic              rx_octet_stb,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic              min_en_q;
    logic [LEN_W-1:0]  min_val_q;

    logic tx_bmin, tx_bmid, tx_bhi, tx_good, tx_mc, tx_bc;
    logic rx_bmin, rx_bmid, rx_bhi, rx_good, rx_mc, rx_bc;

    logic [NUM_CNT-1:0] inc;
    logic [LEN_W-1:0]   amt [NUM_CNT];
    logic [NUM_CNT-1:0] wrap;
    logic [DATA_W-1:0]  cnt_rd [NUM_CNT];
    logic [NUM_CNT-1:0] carry, mask;

    // Minimum-length setting register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_en_q  <= 1'b0;
            min_val_q <= '0;
        end else if (reg_wr && reg_addr == ADDR_W'(ADDR_MINLEN)) begin
            min_en_q  <= reg_wdata[LEN_W];
            min_val_q <= reg_wdata[LEN_W-1:0];
        end
    end

    mac_stats_classify #(.LEN_W(LEN_W)) u_tx_cls (
        .valid(tx_evt_valid), .len(tx_evt_len), .vlan(tx_evt_vlan),
        .ok(tx_evt_ok), .mcast(tx_evt_mcast), .bcast(tx_evt_bcast),
        .min_en(min_en_q), .min_val(min_val_q),
        .bin_min(tx_bmin), .bin_mid(tx_bmid), .bin_hi(tx_bhi),
        .good(tx_good), .good_mc(tx_mc), .good_bc(tx_bc)
    );

    mac_stats_classify #(.LEN_W(LEN_W)) u_rx_cls (
        .valid(rx_evt_valid), .len(rx_evt_len), .vlan(rx_evt_vlan),
        .ok(rx_evt_ok), .mcast(rx_evt_mcast), .bcast(rx_evt_bcast),
        .min_en(min_en_q), .min_val(min_val_q),
        .bin_min(rx_bmin), .bin_mid(rx_bmid), .bin_hi(rx_bhi),
        .good(rx_good), .good_mc(rx_mc), .good_bc(rx_bc)
    );

    // Route classifier results to counter increments and amounts.
    always_comb begin
        for (int i = 0; i < NUM_CNT; i++)
            amt[i] = LEN_W'(1);
        amt[IDX_TX_OCT] = tx_evt_len;
        amt[IDX_RX_OCT] = rx_evt_len;

        inc = '0;
        inc[IDX_TX_MIN]   = tx_bmin;
        inc[IDX_TX_MID]   = tx_bmid;
        inc[IDX_TX_HI]    = tx_bhi;
        inc[IDX_RX_MIN]   = rx_bmin;
        inc[IDX_RX_MID]   = rx_bmid;
        inc[IDX_RX_HI]    = rx_bhi;
        inc[IDX_TX_OCT]   = tx_good;
        inc[IDX_TX_PAUSE] = tx_good && tx_evt_pause;
        inc[IDX_TX_MC]    = tx_mc;
        inc[IDX_TX_BC]    = tx_bc;
        inc[IDX_RX_FRM]   = rx_good;
        inc[IDX_RX_OCT]   = rx_good;
        inc[IDX_RX_RAW]   = rx_octet_stb;
        inc[IDX_RX_MC]    = rx_mc;
        inc[IDX_RX_BC]    = rx_bc;
    end

    // One counter per statistic; width chosen per index.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam int CW = cnt_width(g);
        logic [CW-1:0] v;
        logic          wr_here;

        assign wr_here = reg_wr && (reg_addr == ADDR_W'(g));

        mac_stats_counter #(.W(CW), .AMT_W(LEN_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc(inc[g]), .amt(amt[g]),
            .wr(wr_here), .wdata(reg_wdata[CW-1:0]),
            .value(v), .wrap(wrap[g])
        );

        assign cnt_rd[g] = DATA_W'(v);
    end

    mac_stats_carry #(.N(NUM_CNT)) u_carry (
        .clk(clk), .rst_n(rst_n),
        .wrap(wrap),
        .clr_en(reg_wr && reg_addr == ADDR_W'(ADDR_CARRY)),
        .clr_bits(reg_wdata[NUM_CNT-1:0]),
        .mask_wr(reg_wr && reg_addr == ADDR_W'(ADDR_MASK)),
        .mask_data(reg_wdata[NUM_CNT-1:0]),
        .carry(carry), .mask(mask), .irq(irq)
    );

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < NUM_CNT)
            reg_rdata = cnt_rd[reg_addr];
        else if (reg_addr == ADDR_W'(ADDR_CARRY))
            reg_rdata = DATA_W'(carry);
        else if (reg_addr == ADDR_W'(ADDR_MASK))
            reg_rdata = DATA_W'(mask);
        else if (reg_addr == ADDR_W'(ADDR_MINLEN))
            reg_rdata = DATA_W'({min_en_q, min_val_q});
    end

    // R4: a frame lands in at most one length bin per direction.
    assert_one_bin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_bmin, tx_bmid, tx_bhi}) && $onehot0({rx_bmin, rx_bmid, rx_bhi}));

    // R7: broadcast and multicast strobes never fire together.
    assert_class_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_mc && tx_bc) && !(rx_mc && rx_bc));
endmodule

// File: tb/mac_stats_counters_bench.sv
`timescale 1ns/1ps
module mac_stats_counters_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_evt_valid = 0, tx_evt_vlan = 0, tx_evt_ok = 0;
    logic        tx_evt_mcast = 0, tx_evt_bcast = 0, tx_evt_pause = 0;
    logic [15:0] tx_evt_len = 0;
    logic        rx_evt_valid = 0, rx_evt_vlan = 0, rx_evt_ok = 0;
    logic        rx_evt_mcast = 0, rx_evt_bcast = 0;
    logic [15:0] rx_evt_len = 0;
    logic        rx_octet_stb = 0;
    logic [4:0]  reg_addr = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mac_stats_counters u_mac_stats_counters (
        .clk(clk), .rst_n(rst_n),
        .tx_evt_valid(tx_evt_valid), .tx_evt_len(tx_evt_len), .tx_evt_vlan(tx_evt_vlan),
        .tx_evt_ok(tx_evt_ok), .tx_evt_mcast(tx_evt_mcast), .tx_evt_bcast(tx_evt_bcast),
        .tx_evt_pause(tx_evt_pause),
        .rx_evt_valid(rx_evt_valid), .rx_evt_len(rx_evt_len), .rx_evt_vlan(rx_evt_vlan),
        .rx_evt_ok(rx_evt_ok), .rx_evt_mcast(rx_evt_mcast), .rx_evt_bcast(rx_evt_bcast),
        .rx_octet_stb(rx_octet_stb),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 5'(a);
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 5'(a); reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic tx(input int len, input bit vlan, input bit ok,
                      input bit mc, input bit bc, input bit ps);
        @(negedge clk);
        tx_evt_valid = 1; tx_evt_len = 16'(len); tx_evt_vlan = vlan;
        tx_evt_ok = ok; tx_evt_mcast = mc; tx_evt_bcast = bc; tx_evt_pause = ps;
        @(negedge clk);
        tx_evt_valid = 0;
    endtask

    task automatic rx(input int len, input bit vlan, input bit ok,
                      input bit mc, input bit bc);
        @(negedge clk);
        rx_evt_valid = 1; rx_evt_len = 16'(len); rx_evt_vlan = vlan;
        rx_evt_ok = ok; rx_evt_mcast = mc; rx_evt_bcast = bc;
        @(negedge clk);
        rx_evt_valid = 0;
    endtask

    // Clear every counter and the carry register.
    task automatic clear_all();
        for (int i = 0; i < 15; i++) wr(i, 0);
        wr(16, 32'h7fff);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 19; a++) begin
            rd(a, v);
            check("R1 reset value", v, 0);
        end
        check("R1 irq low", 32'(irq), 0);
        rd(15, v);
        check("R12 unused address", v, 0);
    endtask

    task automatic t_min_bin();
        logic [31:0] v;
        clear_all();
        tx(64, 0, 1, 0, 0, 0);   // untagged min
        tx(64, 1, 1, 0, 0, 0);   // tagged, below 68: no bin
        tx(68, 1, 0, 0, 0, 0);   // tagged min, bad frame
        rx(64, 0, 0, 0, 0);      // bad rx at min
        rx(68, 0, 1, 0, 0);      // untagged 68: mid bin
        rd(0, v); check("R2 tx min bin", v, 2);
        rd(1, v); check("R2 tx mid bin untouched", v, 0);
        rd(3, v); check("R2 rx min bin bad frame", v, 1);
        rd(4, v); check("R2 rx 68 untagged is mid", v, 1);
    endtask

    task automatic t_bins();
        logic [31:0] v;
        clear_all();
        tx(65, 0, 0, 0, 0, 0);
        tx(127, 0, 0, 0, 0, 0);
        tx(128, 0, 0, 0, 0, 0);
        tx(255, 0, 1, 0, 0, 0);
        tx(256, 0, 1, 0, 0, 0);
        tx(63, 0, 1, 0, 0, 0);
        rx(200, 1, 0, 0, 0);
        rx(1500, 0, 1, 0, 0);
        rd(0, v); check("R4 tx min bin", v, 0);
        rd(1, v); check("R4 tx mid bin", v, 2);
        rd(2, v); check("R4 tx upper bin", v, 2);
        rd(5, v); check("R4 rx upper bin bad", v, 1);
        rd(3, v); check("R4 rx long frame no bin", v, 0);
        rd(6, v); check("R4 out-of-bin octets still count", v, 255 + 256 + 63);
    endtask

    task automatic t_progmin();
        logic [31:0] v;
        clear_all();
        wr(18, 32'h0001_0064);
        rd(18, v); check("R3 minlen readback", v, 32'h0001_0064);
        tx(100, 1, 1, 0, 0, 0);
        tx(68, 1, 1, 0, 0, 0);
        tx(101, 0, 1, 0, 0, 0);
        rx(100, 0, 0, 0, 0);
        rd(0, v); check("R3 tx programmed min", v, 1);
        rd(1, v); check("R3 tx above programmed min", v, 1);
        rd(3, v); check("R3 rx programmed min", v, 1);
        wr(18, 0);
        tx(68, 1, 1, 0, 0, 0);
        rd(0, v); check("R3 default restored", v, 2);
    endtask

    task automatic t_octets();
        logic [31:0] v;
        clear_all();
        tx(100, 0, 1, 0, 0, 0);
        tx(200, 0, 0, 0, 0, 0);
        rx(300, 0, 1, 0, 0);
        rx(64, 0, 0, 0, 0);
        rx(70, 0, 1, 0, 0);
        rd(6, v);  check("R5 tx good octets", v, 100);
        rd(11, v); check("R5 rx good octets", v, 370);
        rd(10, v); check("R8 rx good frames", v, 2);
    endtask

    task automatic t_raw();
        logic [31:0] v;
        clear_all();
        @(negedge clk);
        rx_octet_stb = 1;
        repeat (7) @(negedge clk);
        rx_octet_stb = 0;
        @(negedge clk);
        rx_octet_stb = 1;
        rx_evt_valid = 1; rx_evt_len = 64; rx_evt_ok = 0;
        @(negedge clk);
        rx_evt_valid = 0;
        repeat (2) @(negedge clk);
        rx_octet_stb = 0;
        rd(12, v); check("R6 raw octets", v, 10);
        rd(11, v); check("R6 bad frame not in good octets", v, 0);
    endtask

    task automatic t_class();
        logic [31:0] v;
        clear_all();
        tx(64, 0, 1, 1, 0, 0);
        tx(64, 0, 1, 1, 1, 0);
        tx(64, 0, 0, 1, 0, 0);
        tx(64, 0, 0, 0, 1, 0);
        tx(64, 0, 1, 0, 0, 1);
        tx(64, 0, 0, 0, 0, 1);
        rx(64, 0, 1, 1, 0);
        rx(64, 0, 1, 1, 0);
        rx(64, 0, 1, 1, 1);
        rx(64, 0, 0, 1, 1);
        rd(8, v);  check("R7 tx multicast", v, 1);
        rd(9, v);  check("R7 tx broadcast", v, 1);
        rd(13, v); check("R7 rx multicast", v, 2);
        rd(14, v); check("R7 rx broadcast", v, 1);
        rd(7, v);  check("R8 tx pause", v, 1);
    endtask

    task automatic t_write_wrap();
        logic [31:0] v;
        clear_all();
        wr(0, 32'h1234);
        rd(0, v); check("R9 write loads", v, 32'h1234);
        wr(0, 0);
        rd(0, v); check("R9 write zero clears", v, 0);
        // write beats a same-cycle increment
        @(negedge clk);
        rx_octet_stb = 1; reg_wr = 1; reg_addr = 12; reg_wdata = 5;
        @(negedge clk);
        rx_octet_stb = 0; reg_wr = 0;
        rd(12, v); check("R9 write wins", v, 5);

        wr(0, 32'hffff_ffff);
        tx(64, 0, 0, 0, 0, 0);
        rd(0, v);  check("R10 counter wrapped", v, 0);
        rd(16, v); check("R10 carry bit 0", v, 32'h1);
        check("R11 masked irq low", 32'(irq), 0);
        wr(17, 32'h1);
        check("R11 irq high", 32'(irq), 1);
        wr(16, 32'h1);
        rd(16, v); check("R10 W1C clears", v, 0);
        check("R11 irq drops", 32'(irq), 0);

        wr(0, 32'hffff_ffff);
        wr(16, 32'h1);
        @(negedge clk);
        tx_evt_valid = 1; tx_evt_len = 64; tx_evt_vlan = 0; tx_evt_ok = 1;
        tx_evt_mcast = 0; tx_evt_bcast = 0; tx_evt_pause = 0;
        reg_wr = 1; reg_addr = 16; reg_wdata = 32'h1;
        @(negedge clk);
        tx_evt_valid = 0; reg_wr = 0;
        rd(16, v); check("R10 wrap beats clear", v, 32'h1);

        wr(7, 32'h0000_ffff);
        tx(80, 0, 1, 0, 0, 1);
        rd(7, v);  check("R8 pause 16-bit wrap", v, 0);
        rd(16, v); check("R10 pause carry bit 7", v, 32'h81);

        wr(6, 32'hffff_fff0);
        tx(64, 0, 1, 0, 0, 0);
        rd(6, v);  check("R10 octet wrap value", v, 32'h30);
        rd(16, v); check("R10 octet carry bit 6", v, 32'hc1);
        wr(17, 32'h80);
        check("R11 irq from bit 7", 32'(irq), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_min_bin();
        t_bins();
        t_progmin();
        t_octets();
        t_raw();
        t_class();
        t_write_wrap();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule